// File: doc/BRIEF.md
# Bypass Voltage Command Launcher

This block gives a host a direct path for one voltage write to a power-management IC over I2C, outside any automatic voltage sequencing. The host loads a single command word that carries the target I2C device address, the device register to write and the data byte. Setting the launch bit in that word starts the transfer. The block then hands three bytes, one at a time, to an external I2C byte engine through a simple hold-until-done handshake.

The launch bit doubles as the completion indicator. It stays set while the transfer is in flight and the hardware clears it when the device acknowledges the final byte. Software therefore polls the same bit it set. If the device refuses any byte, the block drops the rest of the sequence, clears the launch bit and raises a sticky refusal flag. The host may read the command word back at any time. Writes that arrive while a command is in flight are dropped, so the word under transfer cannot change. After completion, software still allows for the regulator to settle (step count times step size over slew rate, plus about 2 µs); that wait is outside this block.

Command word layout (24 bits): data byte in bits 7:0, device register address in bits 15:8, 7-bit device address in bits 22:16, launch bit in bit 23.

Top module: `vcb_launcher`

## Requirements
- R1: After reset the read-back word is 0, the refusal flag is 0 and no byte is offered (tx_valid low).
- R2: A host write while the launch bit (bit 23) reads 0 stores the whole 24-bit word, which reads back unchanged from the next cycle on; if bit 23 of the write is 0, no byte is offered.
- R3: A write with bit 23 set, taken at clock edge k, makes tx_valid rise after edge k+1 and not before.
- R4: The bytes go out in this order: {device address, 0} with tx_first high, then the register address, then the data byte with tx_last high; only the first byte has tx_first and only the third has tx_last.
- R5: While tx_valid is high and tx_done is low, tx_valid, tx_byte, tx_first and tx_last hold their values.
- R6: The launch bit stays 1 for the whole transfer and reads 0 from the edge where tx_done without tx_nack completes the third byte; bits 22:0 keep the written value.
- R7: tx_done together with tx_nack on any byte ends the sequence at that edge: no further byte is offered, the launch bit reads 0 and the refusal flag reads 1.
- R8: The refusal flag stays 1 across later writes with bit 23 clear and returns to 0 only when a write with bit 23 set is taken.
- R9: Host writes while the launch bit reads 1 are ignored: the read-back word does not change.
- R10: tx_done and tx_nack have no effect while tx_valid is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr_en | input | 1 | Host write strobe for the command word |
| host_wr_data | input | 24 | Command word written by the host |
| host_rd_data | output | 24 | Current command word, launch bit included |
| nack_err | output | 1 | Sticky flag: the device refused a byte |
| tx_valid | output | 1 | A byte is offered to the I2C engine |
| tx_byte | output | 8 | Byte offered to the I2C engine |
| tx_first | output | 1 | Offered byte opens the transfer (start condition) |
| tx_last | output | 1 | Offered byte closes the transfer (stop condition) |
| tx_done | input | 1 | Engine finished the offered byte this cycle |
| tx_nack | input | 1 | With tx_done: the device did not acknowledge the byte |

## Verification
The hardest cases to reach are a host write that lands while a byte is outstanding and a refusal on the middle byte, since both need the engine side and the host side to line up on one cycle. The bench plays the engine itself, holding each byte for a chosen number of cycles before answering, and drives the host write inside that hold window. Refusals are placed in turn on the first, second and third byte, and done pulses are also sent while nothing is offered. A behavioural model tracks the word, the flag and the byte position and is compared against the ports every cycle.

// File: rtl/vcb_pkg.sv
package vcb_pkg;
    parameter int DATA_W    = 8;
    parameter int RADDR_W   = 8;
    parameter int SADDR_W   = 7;
    parameter int BYTE_W    = 8;
    parameter int NUM_BYTES = 3;

    localparam int WORD_W    = DATA_W + RADDR_W + SADDR_W + 1;
    localparam int DATA_LSB  = 0;
    localparam int RADDR_LSB = DATA_LSB + DATA_W;
    localparam int SADDR_LSB = RADDR_LSB + RADDR_W;
    localparam int GO_BIT    = WORD_W - 1;
    localparam int IDX_W     = $clog2(NUM_BYTES);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_BYTES - 1);

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_SEND = 1'b1
    } seq_state_e;
endpackage

// File: rtl/vcb_cmd_reg.sv
module vcb_cmd_reg
    import vcb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              finish,
    input  logic              abort,
    output logic [WORD_W-1:0] word,
    output logic              err
);
    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              err;
    } cmd_state_t;

    cmd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (finish) begin
            // transfer ended: self-clear the launch bit
            st_d.word[GO_BIT] = 1'b0;
            if (abort) begin
                st_d.err = 1'b1;
            end
        end else if (wr_en && !st_q.word[GO_BIT]) begin
            st_d.word = wr_data;
            if (wr_data[GO_BIT]) begin
                st_d.err = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign word = st_q.word;
    assign err  = st_q.err;
endmodule

// File: rtl/vcb_byte_seq.sv
module vcb_byte_seq
    import vcb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic [GO_BIT-1:0] fields,
    input  logic              tx_done,
    input  logic              tx_nack,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_first,
    output logic              tx_last,
    output logic              finish,
    output logic              abort
);
    typedef struct packed {
        seq_state_e       st;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t s_d, s_q;

    logic [BYTE_W-1:0] frame [NUM_BYTES];

    // byte k of the frame: address+write bit, register address, data
    assign frame[0] = {fields[SADDR_LSB +: SADDR_W], 1'b0};
    assign frame[1] = fields[RADDR_LSB +: RADDR_W];
    assign frame[2] = fields[DATA_LSB +: DATA_W];

    logic sending;
    logic byte_end;

    always_comb begin
        sending  = (s_q.st == SEQ_SEND);
        byte_end = sending && tx_done;
        finish   = byte_end && (tx_nack || (s_q.idx == LAST_IDX));
        abort    = byte_end && tx_nack;

        tx_valid = sending;
        tx_byte  = '0;
        for (int k = 0; k < NUM_BYTES; k++) begin
            if (s_q.idx == IDX_W'(k)) begin
                tx_byte = frame[k];
            end
        end
        tx_first = sending && (s_q.idx == '0);
        tx_last  = sending && (s_q.idx == LAST_IDX);

        s_d = s_q;
        if (!sending) begin
            if (go) begin
                s_d.st  = SEQ_SEND;
                s_d.idx = '0;
            end
        end else if (finish) begin
            s_d.st  = SEQ_IDLE;
            s_d.idx = '0;
        end else if (byte_end) begin
            s_d.idx = s_q.idx + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: SEQ_IDLE, idx: '0};
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/vcb_launcher.sv
module vcb_launcher
    import vcb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr_en,
    input  logic [WORD_W-1:0] host_wr_data,
    output logic [WORD_W-1:0] host_rd_data,
    output logic              nack_err,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_first,
    output logic              tx_last,
    input  logic              tx_done,
    input  logic              tx_nack
);
    logic [WORD_W-1:0] word;
    logic              finish;
    logic              abort;

    vcb_cmd_reg u_cmd (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (host_wr_en),
        .wr_data (host_wr_data),
        .finish  (finish),
        .abort   (abort),
        .word    (word),
        .err     (nack_err)
    );

    vcb_byte_seq u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (word[GO_BIT]),
        .fields   (word[GO_BIT-1:0]),
        .tx_done  (tx_done),
        .tx_nack  (tx_nack),
        .tx_valid (tx_valid),
        .tx_byte  (tx_byte),
        .tx_first (tx_first),
        .tx_last  (tx_last),
        .finish   (finish),
        .abort    (abort)
    );

    assign host_rd_data = word;
endmodule

// File: rtl/vcb_launcher_chk.sv
module vcb_launcher_chk
    import vcb_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr_en,
    input logic [WORD_W-1:0] host_rd_data,
    input logic              nack_err,
    input logic              tx_valid,
    input logic [BYTE_W-1:0] tx_byte,
    input logic              tx_first,
    input logic              tx_last,
    input logic              tx_done,
    input logic              tx_nack
);
    assert_launch_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(host_rd_data[GO_BIT]) |=> tx_valid);

    assert_first_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> (tx_first && !tx_last &&
            tx_byte == {host_rd_data[SADDR_LSB +: SADDR_W], 1'b0}));

    assert_byte_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_done) |=> (tx_valid && $stable(tx_byte) &&
            $stable(tx_first) && $stable(tx_last)));

    assert_busy_go_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> host_rd_data[GO_BIT]);

    assert_clear_on_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_rd_data[GO_BIT]) |-> $past(tx_valid && tx_done));

    assert_nack_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_done && tx_nack) |=>
            (nack_err && !host_rd_data[GO_BIT] && !tx_valid));

    assert_busy_write_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr_en && host_rd_data[GO_BIT] && !(tx_valid && tx_done)) |=>
            ($stable(host_rd_data) && $stable(nack_err)));
endmodule

bind vcb_launcher vcb_launcher_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr_en   (host_wr_en),
    .host_rd_data (host_rd_data),
    .nack_err     (nack_err),
    .tx_valid     (tx_valid),
    .tx_byte      (tx_byte),
    .tx_first     (tx_first),
    .tx_last      (tx_last),
    .tx_done      (tx_done),
    .tx_nack      (tx_nack)
);

// File: tb/vcb_launcher_tb.sv
module vcb_launcher_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [23:0] host_wr_data = '0;
    logic [23:0] host_rd_data;
    logic        nack_err;
    logic        tx_valid;
    logic [7:0]  tx_byte;
    logic        tx_first;
    logic        tx_last;
    logic        tx_done = 1'b0;
    logic        tx_nack = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    vcb_launcher u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .host_wr_en   (host_wr_en),
        .host_wr_data (host_wr_data),
        .host_rd_data (host_rd_data),
        .nack_err     (nack_err),
        .tx_valid     (tx_valid),
        .tx_byte      (tx_byte),
        .tx_first     (tx_first),
        .tx_last      (tx_last),
        .tx_done      (tx_done),
        .tx_nack      (tx_nack)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    logic [23:0] m_word = '0;
    bit          m_busy = 1'b0;
    bit          m_err  = 1'b0;
    int          m_idx  = 0;

    function automatic logic [7:0] m_byte(input int idx);
        if (idx == 0)      return {m_word[22:16], 1'b0};
        else if (idx == 1) return m_word[15:8];
        else               return m_word[7:0];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_word = '0; m_busy = 1'b0; m_err = 1'b0; m_idx = 0;
        end else begin
            bit old_go;
            old_go = m_word[23];
            if (m_busy) begin
                if (tx_done) begin
                    if (tx_nack) begin
                        m_busy = 1'b0; m_word[23] = 1'b0; m_err = 1'b1;
                    end else if (m_idx == 2) begin
                        m_busy = 1'b0; m_word[23] = 1'b0;
                    end else begin
                        m_idx++;
                    end
                end
            end else if (old_go) begin
                m_busy = 1'b1; m_idx = 0;
            end
            if (host_wr_en && !old_go) begin
                m_word = host_wr_data;
                if (host_wr_data[23]) m_err = 1'b0;
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R2 R6 R9 readback", {8'h0, host_rd_data}, {8'h0, m_word});
            chk("R7 R8 refusal flag", {31'h0, nack_err}, {31'h0, m_err});
            chk("R3 R6 R7 R10 tx_valid", {31'h0, tx_valid}, {31'h0, m_busy});
            if (m_busy) begin
                chk("R4 R5 byte/first/last", {22'h0, tx_first, tx_last, tx_byte},
                    {22'h0, m_idx == 0, m_idx == 2, m_byte(m_idx)});
            end
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected<=20000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic host_write(input logic [23:0] w);
        @(negedge clk);
        host_wr_en = 1'b1; host_wr_data = w;
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic launch(input logic [23:0] w);
        host_write(w);
        chk("R3 not yet offered", {31'h0, tx_valid}, 32'h0);
        @(negedge clk);
        chk("R3 offered one cycle later", {31'h0, tx_valid}, 32'h1);
    endtask

    task automatic serve(input int hold, input bit nack, input logic [7:0] exp, input string tag);
        chk(tag, {24'h0, tx_byte}, {24'h0, exp});
        repeat (hold) @(negedge clk);
        chk("R5 byte held", {24'h0, tx_byte}, {24'h0, exp});
        tx_done = 1'b1; tx_nack = nack;
        @(negedge clk);
        tx_done = 1'b0; tx_nack = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset word", {8'h0, host_rd_data}, 32'h0);
        chk("R1 reset flag", {31'h0, nack_err}, 32'h0);
        chk("R1 reset tx_valid", {31'h0, tx_valid}, 32'h0);

        // R2: plain store, no transfer
        host_write(24'h123456);
        chk("R2 stored", {8'h0, host_rd_data}, 32'h123456);
        repeat (2) @(negedge clk);
        chk("R2 no byte offered", {31'h0, tx_valid}, 32'h0);

        // full transfer with a busy write in the middle
        launch(24'hC85A3C);
        serve(0, 1'b0, 8'h90, "R4 byte0 address+write");
        host_wr_en = 1'b1; host_wr_data = 24'h800001;
        @(negedge clk);
        host_wr_en = 1'b0;
        chk("R9 busy write ignored", {8'h0, host_rd_data}, 32'hC85A3C);
        serve(3, 1'b0, 8'h5A, "R4 byte1 register");
        chk("R6 launch bit still set", {31'h0, host_rd_data[23]}, 32'h1);
        serve(1, 1'b0, 8'h3C, "R4 byte2 data");
        chk("R6 self-cleared", {8'h0, host_rd_data}, 32'h485A3C);
        chk("R6 nothing offered", {31'h0, tx_valid}, 32'h0);

        // refusal on the middle byte
        launch(24'h923456);
        serve(2, 1'b0, 8'h24, "R4 byte0");
        serve(0, 1'b1, 8'h34, "R4 byte1");
        chk("R7 flag set", {31'h0, nack_err}, 32'h1);
        chk("R7 launch cleared", {8'h0, host_rd_data}, 32'h123456);
        repeat (2) @(negedge clk);
        chk("R7 no more bytes", {31'h0, tx_valid}, 32'h0);

        // R8: non-launch write keeps the flag
        host_write(24'h010203);
        chk("R8 flag kept", {31'h0, nack_err}, 32'h1);

        // R10: done pulses while idle
        @(negedge clk);
        tx_done = 1'b1; tx_nack = 1'b1;
        repeat (2) @(negedge clk);
        tx_done = 1'b0; tx_nack = 1'b0;
        chk("R10 word unchanged", {8'h0, host_rd_data}, 32'h010203);
        chk("R10 flag unchanged", {31'h0, nack_err}, 32'h1);

        // R8: launch clears the flag; refusal on first byte
        launch(24'hFF00FF);
        chk("R8 flag cleared by launch", {31'h0, nack_err}, 32'h0);
        serve(1, 1'b1, 8'hFE, "R4 byte0 max address");
        chk("R7 refused first byte", {31'h0, nack_err}, 32'h1);

        // refusal on last byte
        launch(24'hC85A3C);
        serve(0, 1'b0, 8'h90, "R4 byte0");
        serve(0, 1'b0, 8'h5A, "R4 byte1");
        serve(4, 1'b1, 8'h3C, "R4 byte2");
        chk("R7 refused last byte", {31'h0, nack_err}, 32'h1);
        chk("R7 launch cleared last", {31'h0, host_rd_data[23]}, 32'h0);

        // clean run after refusals
        launch(24'h800000);
        serve(0, 1'b0, 8'h00, "R4 byte0 zero");
        serve(0, 1'b0, 8'h00, "R4 byte1 zero");
        serve(0, 1'b0, 8'h00, "R4 byte2 zero");
        chk("R6 clean finish", {8'h0, host_rd_data}, 32'h0);
        chk("R8 clean flag", {31'h0, nack_err}, 32'h0);

        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule